// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function I/O controller. It sits on a small 8-bit I/O bus with two byte addresses. The lower address holds a register pointer and the upper address moves data to or from the register that the pointer selects. The port ignores software until a fixed two-byte key has been written to the pointer address. A single closing byte then shuts it again. This keeps stray bus traffic from changing the setup of the functions behind it.

While the port is open it holds a small global group of registers: a device-select number, a fixed identity byte and a revision byte. It also holds one bank of registers for each implemented function. The device-select number chooses which bank answers. Each bank has an enable bit and a 16-bit I/O base address that the function it belongs to would use.

Bank positions 0x04 and 0x05 are left empty, as is every number from NUM_LDN upward. Reads from an empty position return zero and writes to it are dropped. Read data is combinational: it reflects the register state present before the clock edge on which the read strobe is sampled.

Top module: `sio_cfg_port`

## Requirements
- R1: Bus offset 0 (io_addr=0) is the pointer (index) port and offset 1 (io_addr=1) is the data port. While open, a read of offset 0 returns the stored pointer and a read of offset 1 returns the register that the pointer selects.
- R2: The port opens only after 0x87 is written to offset 0 on two index-port writes in a row. Data-port writes in between do not disturb this sequence.
- R3: While open, writing 0xAA to offset 0 closes the port and leaves the stored pointer unchanged.
- R4: Pointer 0x20 reads the identity byte 0x3C and pointer 0x21 reads the revision byte (parameter REVISION, default 0x11). Data writes to either pointer change nothing.
- R5: While closed, reads of either offset return 0xFF. Data-port writes change no register, and index-port writes do not change the stored pointer.
- R6: While closed, an index-port write of any value other than 0x87 restarts the key, so the next 0x87 counts as the first of two.
- R7: Pointer 0x07 is a read/write 8-bit device-select number. The per-device registers that are read and written are those of the bank it names.
- R8: Pointer 0x30 holds the selected bank's enable flag in bit 0. Bit 0 reads back the last value written, bits 7:1 read 0, and each bank keeps its own flag.
- R9: Pointer 0x60 holds bits 15:8 and pointer 0x61 holds bits 7:0 of the selected bank's base address. Each bank keeps its own value.
- R10: An unimplemented pointer, or a per-device pointer while the device-select number names an empty position (0x04, 0x05, or 0x0E and above), reads 0x00. Writes to it leave every bank unchanged.
- R11: After reset the port is closed, the pointer and the device-select number are 0, and every enable flag and base address is 0.
- R12: When a read and a write strobe fall in the same cycle, the read returns the state before that write, and the write still takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 1 | Byte offset: 0 pointer, 1 data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |

## Verification
Two of the block's functions can share one cycle: a read of a register, and a write that changes that same register or closes the port. The bench provokes this by raising the read and write strobes together. In one case it writes the high base-address byte while reading it back. In the other it writes the closing byte to the pointer port while reading that port. Each combined cycle is judged twice. The read in that cycle must show the value from before the write. A later read must show the new base address, or 0xFF from the now closed port.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the configuration port.
// Assumes 8-bit registers and 8-bit pointer values throughout.
package sio_cfg_pkg;
    localparam logic [7:0] KEY_OPEN    = 8'h87;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;
    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_ID      = 8'h20;
    localparam logic [7:0] REG_REV     = 8'h21;
    localparam logic [7:0] REG_ACT     = 8'h30;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;
    localparam logic [7:0] DEV_ID      = 8'h3C;
    localparam logic [7:0] SHUT_READ   = 8'hFF;

    typedef enum logic [1:0] {
        LK_SHUT  = 2'd0,
        LK_ARMED = 2'd1,
        LK_OPEN  = 2'd2
    } lock_state_t;
endpackage

// File: rtl/sio_cfg_unlock.sv
`timescale 1ns/1ps
// Module: key sequencer for the configuration port.
// Watches index-port writes only. Two 0x87 writes in a row open the port,
// and 0xAA closes it. Assumes idx_wr is high for one cycle per bus write.
module sio_cfg_unlock
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open
);
    lock_state_t state_q;

    // Advance the key state on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_SHUT;
        end else if (idx_wr) begin
            unique case (state_q)
                LK_SHUT:  state_q <= (wdata == KEY_OPEN)  ? LK_ARMED : LK_SHUT;
                LK_ARMED: state_q <= (wdata == KEY_OPEN)  ? LK_OPEN  : LK_SHUT;
                LK_OPEN:  state_q <= (wdata == KEY_CLOSE) ? LK_SHUT  : LK_OPEN;
                default:  state_q <= LK_SHUT;
            endcase
        end
    end

    // Expose the open flag to the register logic.
    assign cfg_open = (state_q == LK_OPEN);

    assert_open_after_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(state_q == LK_ARMED && idx_wr));

    assert_close_on_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && wdata == KEY_CLOSE) |=> !cfg_open);

    assert_restart_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARMED && idx_wr && wdata != KEY_OPEN) |=> state_q == LK_SHUT);
endmodule

// File: rtl/sio_cfg_dev_bank.sv
`timescale 1ns/1ps
// Module: register bank for one logical device (enable flag and base address).
// Assumes wr_en is already qualified by port-open, data-port and bank select.
// rdata is zero unless this bank is selected.
module sio_cfg_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [7:0]        reg_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic              act_q;
    logic [DATA_W-1:0] base_hi_q;
    logic [DATA_W-1:0] base_lo_q;

    // Store writes aimed at this bank's registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            base_hi_q <= '0;
            base_lo_q <= '0;
        end else if (wr_en) begin
            case (reg_idx)
                REG_ACT:     act_q     <= wdata[0];
                REG_BASE_HI: base_hi_q <= wdata;
                REG_BASE_LO: base_lo_q <= wdata;
                default: ;
            endcase
        end
    end

    // Return the selected register when this bank is chosen.
    always_comb begin
        rdata = '0;
        if (sel) begin
            case (reg_idx)
                REG_ACT:     rdata = {{(DATA_W-1){1'b0}}, act_q};
                REG_BASE_HI: rdata = base_hi_q;
                REG_BASE_LO: rdata = base_lo_q;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
// Module: two-address configuration port with key lock and banked
// per-device registers. Assumes single-cycle read and write strobes on a
// simple I/O bus. Read data is combinational from the current state.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int             NUM_LDN  = 14,
    parameter logic [NUM_LDN-1:0] GAP_MASK = 14'h0030,
    parameter logic [7:0]     REVISION = 8'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_addr,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata
);
    localparam int DATA_W = 8;

    logic              cfg_open;
    logic              idx_wr;
    logic              dat_wr;
    logic [7:0]        index_q;
    logic [7:0]        ldn_q;
    logic [NUM_LDN-1:0] dev_sel;
    logic [DATA_W-1:0] dev_rd [NUM_LDN];
    logic [DATA_W-1:0] dev_rd_any;

    // Decode bus writes by offset; data writes count only while open.
    assign idx_wr = io_wr && !io_addr;
    assign dat_wr = io_wr && io_addr && cfg_open;

    sio_cfg_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .cfg_open (cfg_open)
    );

    // Pointer register: loads on open index writes other than the close key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (idx_wr && cfg_open && io_wdata != KEY_CLOSE) begin
            index_q <= io_wdata;
        end
    end

    // Device-select register at its global pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q <= '0;
        end else if (dat_wr && index_q == REG_LDN) begin
            ldn_q <= io_wdata;
        end
    end

    // One bank per implemented device number; gaps read zero.
    for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
        if (!GAP_MASK[g]) begin : g_bank
            assign dev_sel[g] = (ldn_q == 8'(g));
            sio_cfg_dev_bank #(.DATA_W(DATA_W)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel     (dev_sel[g]),
                .wr_en   (dat_wr && dev_sel[g]),
                .reg_idx (index_q),
                .wdata   (io_wdata),
                .rdata   (dev_rd[g])
            );
        end else begin : g_gap
            assign dev_sel[g] = 1'b0;
            assign dev_rd[g]  = '0;
        end
    end

    // Merge bank read data; at most one bank is selected.
    always_comb begin
        dev_rd_any = '0;
        for (int k = 0; k < NUM_LDN; k++) begin
            dev_rd_any = dev_rd_any | dev_rd[k];
        end
    end

    // Read mux: closed port, pointer port, or register selected by pointer.
    always_comb begin
        if (!cfg_open) begin
            io_rdata = SHUT_READ;
        end else if (!io_addr) begin
            io_rdata = index_q;
        end else begin
            case (index_q)
                REG_LDN: io_rdata = ldn_q;
                REG_ID:  io_rdata = DEV_ID;
                REG_REV: io_rdata = REVISION;
                default: io_rdata = dev_rd_any;
            endcase
        end
    end

    assert_shut_reads_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd) |-> io_rdata == 8'hFF);

    assert_shut_state_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr) |=> ($stable(index_q) && $stable(ldn_q)));

    assert_id_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_rd && io_addr && index_q == REG_ID) |-> io_rdata == 8'h3C);

    assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));
endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_addr = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    sio_cfg_port i_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    // Monitor: compare every strobed read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && io_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %02h expected none", io_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, io_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic rw(input logic a, input logic [7:0] d, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
        wr(1'b0, idx); wr(1'b1, d);
    endtask

    task automatic finish_run;
        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 and R5: closed after reset
        rd(1'b1, 8'hFF, "R11 closed data");
        rd(1'b0, 8'hFF, "R5 closed index");
        // R2: key with a data write in between
        wr(1'b0, 8'h87); wr(1'b1, 8'h55); wr(1'b0, 8'h87);
        rd(1'b0, 8'h00, "R11 R1 pointer zero");
        wr(1'b0, 8'h07);
        rd(1'b1, 8'h00, "R11 ldn zero");
        rd(1'b0, 8'h07, "R1 pointer readback");
        wr(1'b0, 8'h30);
        rd(1'b1, 8'h00, "R11 enable zero");
        // R4: identity and revision are read-only
        wr(1'b0, 8'h20);
        rd(1'b1, 8'h3C, "R4 id");
        wr(1'b1, 8'h12);
        rd(1'b1, 8'h3C, "R4 id after write");
        set_reg(8'h21, 8'h99);
        rd(1'b1, 8'h11, "R4 revision");
        // R7 R8 R9: bank 0x0B
        set_reg(8'h07, 8'h0B);
        rd(1'b1, 8'h0B, "R7 ldn readback");
        set_reg(8'h30, 8'hFF);
        rd(1'b1, 8'h01, "R8 enable bit only");
        set_reg(8'h60, 8'hAB);
        set_reg(8'h61, 8'hCD);
        rd(1'b1, 8'hCD, "R9 base low");
        wr(1'b0, 8'h60);
        rd(1'b1, 8'hAB, "R9 base high");
        // R8 R9: bank 0x02 is separate
        set_reg(8'h07, 8'h02);
        wr(1'b0, 8'h30);
        rd(1'b1, 8'h00, "R8 other bank enable");
        set_reg(8'h60, 8'h12);
        rd(1'b1, 8'h12, "R9 other bank base");
        set_reg(8'h07, 8'h0B);
        wr(1'b0, 8'h60);
        rd(1'b1, 8'hAB, "R9 bank kept base");
        // R10: empty positions and unknown pointer
        set_reg(8'h07, 8'h04);
        set_reg(8'h30, 8'h01);
        rd(1'b1, 8'h00, "R10 gap enable");
        set_reg(8'h60, 8'h77);
        rd(1'b1, 8'h00, "R10 gap base");
        set_reg(8'h07, 8'h0E);
        set_reg(8'h60, 8'h66);
        rd(1'b1, 8'h00, "R10 beyond range");
        set_reg(8'h55, 8'h9A);
        rd(1'b1, 8'h00, "R10 unknown pointer");
        set_reg(8'h07, 8'h0B);
        wr(1'b0, 8'h30);
        rd(1'b1, 8'h01, "R10 bank untouched enable");
        wr(1'b0, 8'h60);
        rd(1'b1, 8'hAB, "R10 bank untouched base");
        // R12: read and write of the same register in one cycle
        rw(1'b1, 8'h5A, 8'hAB, "R12 read old base");
        rd(1'b1, 8'h5A, "R12 write landed");
        // R12 R3: close while reading pointer port
        rw(1'b0, 8'hAA, 8'h60, "R12 read pointer at close");
        rd(1'b1, 8'hFF, "R3 closed after key");
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h11);
        wr(1'b0, 8'h87); wr(1'b0, 8'h87);
        rd(1'b0, 8'h60, "R3 R5 pointer unchanged");
        rd(1'b1, 8'h5A, "R5 closed data write ignored");
        // R6: broken key restarts
        wr(1'b0, 8'hAA);
        wr(1'b0, 8'h87); wr(1'b0, 8'h11); wr(1'b0, 8'h87);
        rd(1'b1, 8'hFF, "R6 still closed");
        wr(1'b0, 8'h87);
        rd(1'b0, 8'h60, "R6 open after two in a row");
        finish_run();
    end
endmodule